// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block gives two clock domains a way to pass single words to each other without going through the main queue. It holds two one-word mailboxes. The first carries a word from the A side to the B side. The second carries a word from the B side back to the A side.

Each side has its own clock, active-low chip select, enable, direction select and mailbox select. Each mailbox has an active-low "holding mail" flag in the domain that writes it. While that flag is low, the mailbox refuses further writes. The flag returns high only after the other side has read the word.

Arrival and acknowledge events cross between the clocks as toggles, each through a two-flop synchronizer. On a read with the mailbox select low, the side returns the queue data presented on its queue input instead of mailbox data.

Each mailbox direction uses two small state machines:

- The posting machine runs in the writing domain. It has two states, `POST_OPEN` (empty, writes accepted) and `POST_HELD` (full, writes ignored). Its transitions are named `post_accept` (`POST_OPEN` to `POST_HELD`, on an accepted write) and `post_acked` (`POST_HELD` to `POST_OPEN`, when the synchronized acknowledge toggle matches the post toggle).
- The taking machine runs in the reading domain. It has two states, `TAKE_EMPTY` and `TAKE_READY`. Its transitions are named `take_arrive` (`TAKE_EMPTY` to `TAKE_READY`, when the synchronized post toggle differs from the acknowledge toggle) and `take_consume` (`TAKE_READY` to `TAKE_EMPTY`, on a mailbox read, which flips the acknowledge toggle).

Top module: `mailbox_bridge`

## Requirements
- R1: A side operation with a_cs_n=0, a_en=1, a_wr_rd_n=1, a_mbx=1 while mbx1_full_n is high stores a_din into mailbox 1 and drives mbx1_full_n low after that clk_a edge.
- R2: While mbx1_full_n is low, further A side mailbox writes are ignored, so the word later read on side B is the first one.
- R3: A B side read (b_cs_n=0, b_en=1, b_rd_wr_n=1, b_mbx=1) of arrived mail puts mailbox 1 on b_dout after that clk_b edge. mbx1_full_n then returns high within five clk_a cycles.
- R4: A B side mailbox write (b_rd_wr_n=0, b_mbx=1) while mbx2_full_n is high stores b_din into mailbox 2 and drives mbx2_full_n low after that clk_b edge. Further B side mailbox writes are ignored while mbx2_full_n is low.
- R5: An A side read (a_wr_rd_n=0, a_mbx=1) of arrived mail puts mailbox 2 on a_dout after that clk_a edge. mbx2_full_n then returns high within five clk_b cycles.
- R6: rst_n low or part_rst_n low drives both flags high and both data outputs to zero.
- R7: A side does nothing on an edge where chip select is high or enable is low: no flag, mailbox or output change.
- R8: A read with the mailbox select low loads that side's queue data input into its data output and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | A side clock |
| clk_b | input | 1 | B side clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| part_rst_n | input | 1 | Partial reset, active low, asynchronous |
| a_cs_n | input | 1 | A side chip select, active low |
| a_en | input | 1 | A side enable |
| a_wr_rd_n | input | 1 | A side direction: 1 write, 0 read |
| a_mbx | input | 1 | A side mailbox select |
| a_din | input | DATA_W | A side write data |
| a_fifo_data | input | DATA_W | Queue data offered to A side reads |
| a_dout | output | DATA_W | A side read data register |
| b_cs_n | input | 1 | B side chip select, active low |
| b_en | input | 1 | B side enable |
| b_rd_wr_n | input | 1 | B side direction: 1 read, 0 write |
| b_mbx | input | 1 | B side mailbox select |
| b_din | input | DATA_W | B side write data |
| b_fifo_data | input | DATA_W | Queue data offered to B side reads |
| b_dout | output | DATA_W | B side read data register |
| mbx1_full_n | output | 1 | Mailbox 1 holds mail when low (clk_a domain) |
| mbx2_full_n | output | 1 | Mailbox 2 holds mail when low (clk_b domain) |

## Verification
On every cycle, the assertions check three things: an accepted write drops the flag, a write on a full mailbox leaves the stored word stable, and a consuming read empties the taking machine. They also check that synchronizer outputs only copy their first stage and that a mailbox read loads the stored word. Only the bench scenarios can show the full round trip across both clocks: the flag returns high after the far side reads, the first word survives a blocked second write, and a partial reset in the middle of a transfer clears the flags. The bench also checks that gated edges change nothing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        POST_OPEN = 1'b0,
        POST_HELD = 1'b1
    } post_state_t;

    typedef enum logic {
        TAKE_EMPTY = 1'b0,
        TAKE_READY = 1'b1
    } take_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];

    assert_sync_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> (q == $past(chain[LAST-1])));
endmodule

// File: rtl/mbx_post.sv
module mbx_post
    import mbx_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_tog_s,
    output logic              post_tog,
    output logic [DATA_W-1:0] mail_q,
    output logic              full_n
);
    post_state_t state, state_nx;
    logic        post_accept;
    logic        post_acked;

    always_comb begin
        post_accept = 1'b0;
        post_acked  = 1'b0;
        state_nx    = state;
        unique case (state)
            POST_OPEN: begin
                if (wr_req) begin
                    post_accept = 1'b1;
                    state_nx    = POST_HELD;
                end
            end
            POST_HELD: begin
                if (ack_tog_s == post_tog) begin
                    post_acked = 1'b1;
                    state_nx   = POST_OPEN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= POST_OPEN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_tog <= 1'b0;
            mail_q   <= '0;
        end else if (post_accept) begin
            post_tog <= ~post_tog;
            mail_q   <= din;
        end
    end

    assign full_n = (state == POST_OPEN);

    assert_post_flag_falls_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_n && wr_req) |=> !full_n);
    assert_post_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_req) |=> $stable(mail_q));
endmodule

// File: rtl/mbx_take.sv
module mbx_take
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic post_tog_s,
    output logic ack_tog,
    output logic ready
);
    take_state_t state, state_nx;
    logic        take_arrive;
    logic        take_consume;

    always_comb begin
        take_arrive  = 1'b0;
        take_consume = 1'b0;
        state_nx     = state;
        unique case (state)
            TAKE_EMPTY: begin
                if (post_tog_s != ack_tog) begin
                    take_arrive = 1'b1;
                    state_nx    = TAKE_READY;
                end
            end
            TAKE_READY: begin
                if (rd_req) begin
                    take_consume = 1'b1;
                    state_nx     = TAKE_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TAKE_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ack_tog <= 1'b0;
        else if (take_consume) ack_tog <= ~ack_tog;
    end

    assign ready = (state == TAKE_READY);

    assert_take_consume_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_req) |=> (!ready && (post_tog_s == ack_tog)));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int DATA_W = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              clk_r,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_req,
    output logic [DATA_W-1:0] mail_q,
    output logic              full_n
);
    logic post_tog, post_tog_s;
    logic ack_tog, ack_tog_s;
    logic ready;

    mbx_post #(.DATA_W(DATA_W)) u_post (
        .clk(clk_w), .rst_n(rst_n), .wr_req(wr_req), .din(din),
        .ack_tog_s(ack_tog_s), .post_tog(post_tog), .mail_q(mail_q), .full_n(full_n)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_post (
        .clk(clk_r), .rst_n(rst_n), .d(post_tog), .q(post_tog_s)
    );

    mbx_take u_take (
        .clk(clk_r), .rst_n(rst_n), .rd_req(rd_req), .post_tog_s(post_tog_s),
        .ack_tog(ack_tog), .ready(ready)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk_w), .rst_n(rst_n), .d(ack_tog), .q(ack_tog_s)
    );
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge #(
    parameter int DATA_W = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              part_rst_n,
    input  logic              a_cs_n,
    input  logic              a_en,
    input  logic              a_wr_rd_n,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_data,
    output logic [DATA_W-1:0] a_dout,
    input  logic              b_cs_n,
    input  logic              b_en,
    input  logic              b_rd_wr_n,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_data,
    output logic [DATA_W-1:0] b_dout,
    output logic              mbx1_full_n,
    output logic              mbx2_full_n
);
    logic              clr_n;
    logic              a_go, b_go;
    logic              a_mb_wr, a_rd, b_mb_wr, b_rd;
    logic [DATA_W-1:0] mail1_q, mail2_q;

    assign clr_n   = rst_n & part_rst_n;
    assign a_go    = !a_cs_n && a_en;
    assign b_go    = !b_cs_n && b_en;
    assign a_mb_wr = a_go && a_wr_rd_n && a_mbx;
    assign a_rd    = a_go && !a_wr_rd_n;
    assign b_mb_wr = b_go && !b_rd_wr_n && b_mbx;
    assign b_rd    = b_go && b_rd_wr_n;

    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
        .clk_w(clk_a), .clk_r(clk_b), .rst_n(clr_n),
        .wr_req(a_mb_wr), .din(a_din), .rd_req(b_rd && b_mbx),
        .mail_q(mail1_q), .full_n(mbx1_full_n)
    );

    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
        .clk_w(clk_b), .clk_r(clk_a), .rst_n(clr_n),
        .wr_req(b_mb_wr), .din(b_din), .rd_req(a_rd && a_mbx),
        .mail_q(mail2_q), .full_n(mbx2_full_n)
    );

    always_ff @(posedge clk_a or negedge clr_n) begin
        if (!clr_n)    a_dout <= '0;
        else if (a_rd) a_dout <= a_mbx ? mail2_q : a_fifo_data;
    end

    always_ff @(posedge clk_b or negedge clr_n) begin
        if (!clr_n)    b_dout <= '0;
        else if (b_rd) b_dout <= b_mbx ? mail1_q : b_fifo_data;
    end

    assert_a_mail_out_R5: assert property (@(posedge clk_a) disable iff (!clr_n)
        (a_rd && a_mbx) |=> (a_dout == $past(mail2_q)));
    assert_b_fifo_out_R8: assert property (@(posedge clk_b) disable iff (!clr_n)
        (b_rd && !b_mbx) |=> (b_dout == $past(b_fifo_data)));
    assert_a_idle_R7: assert property (@(posedge clk_a) disable iff (!clr_n)
        (!a_go) |=> $stable(a_dout));
endmodule

// File: tb/mailbox_bridge_bench.sv
`timescale 1ns/1ps
module mailbox_bridge_bench;
    localparam int W = 36;

    logic clk_a = 0, clk_b = 0;
    logic rst_n = 0, part_rst_n = 1;
    logic a_cs_n = 1, a_en = 0, a_wr_rd_n = 0, a_mbx = 0;
    logic b_cs_n = 1, b_en = 0, b_rd_wr_n = 1, b_mbx = 0;
    logic [W-1:0] a_din = '0, a_fifo_data = '0, b_din = '0, b_fifo_data = '0;
    logic [W-1:0] a_dout, b_dout;
    logic mbx1_full_n, mbx2_full_n;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    mailbox_bridge #(.DATA_W(W)) u_mailbox_bridge (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .part_rst_n(part_rst_n),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr_rd_n(a_wr_rd_n), .a_mbx(a_mbx),
        .a_din(a_din), .a_fifo_data(a_fifo_data), .a_dout(a_dout),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_rd_wr_n(b_rd_wr_n), .b_mbx(b_mbx),
        .b_din(b_din), .b_fifo_data(b_fifo_data), .b_dout(b_dout),
        .mbx1_full_n(mbx1_full_n), .mbx2_full_n(mbx2_full_n)
    );

    function automatic logic [W-1:0] exp_read(input logic mbx, input logic [W-1:0] mail,
                                              input logic [W-1:0] fifo);
        return mbx ? mail : fifo;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_a(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(negedge clk_b);
    endtask

    task automatic a_op(input logic cs_n, input logic en, input logic wr, input logic mbx,
                        input logic [W-1:0] d, input logic [W-1:0] fifo);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr_rd_n = wr; a_mbx = mbx; a_din = d; a_fifo_data = fifo;
        @(negedge clk_a);
        a_cs_n = 1; a_en = 0; a_mbx = 0;
    endtask

    task automatic b_op(input logic cs_n, input logic en, input logic rd, input logic mbx,
                        input logic [W-1:0] d, input logic [W-1:0] fifo);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_rd_wr_n = rd; b_mbx = mbx; b_din = d; b_fifo_data = fifo;
        @(negedge clk_b);
        b_cs_n = 1; b_en = 0; b_mbx = 0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d1, d2, v, held;
        void'($urandom(32'h1d2c3b4a));
        d1 = 36'h1_2345_6789;
        d2 = 36'hF_EDCB_A987;

        wait_a(4);
        rst_n = 1;
        wait_b(3);
        // R6: reset state
        check(mbx1_full_n == 1, "R6 flag1 reset", W'(mbx1_full_n), 1);
        check(mbx2_full_n == 1, "R6 flag2 reset", W'(mbx2_full_n), 1);
        check(a_dout == 0 && b_dout == 0, "R6 outputs reset", a_dout | b_dout, 0);

        // R7: gated edges
        a_op(1, 1, 1, 1, d1, 0);
        check(mbx1_full_n == 1, "R7 cs high write", W'(mbx1_full_n), 1);
        a_op(0, 0, 1, 1, d1, 0);
        check(mbx1_full_n == 1, "R7 en low write", W'(mbx1_full_n), 1);
        a_op(1, 1, 0, 0, 0, 36'h77);
        check(a_dout == 0, "R7 cs high read", a_dout, 0);

        // R1 / R2
        a_op(0, 1, 1, 1, d1, 0);
        check(mbx1_full_n == 0, "R1 flag1 low", W'(mbx1_full_n), 0);
        a_op(0, 1, 1, 1, d2, 0);
        check(mbx1_full_n == 0, "R2 still full", W'(mbx1_full_n), 0);
        wait_b(5);
        // R3: read on side B
        b_op(0, 1, 1, 1, 0, 0);
        check(b_dout == d1, "R2 R3 first word kept", b_dout, d1);
        wait_a(5);
        check(mbx1_full_n == 1, "R3 flag1 high", W'(mbx1_full_n), 1);

        // R8: queue read on side B
        b_op(0, 1, 1, 0, 0, 36'hA_BCDE_0001);
        check(b_dout == 36'hA_BCDE_0001, "R8 b queue read", b_dout, 36'hA_BCDE_0001);
        check(mbx1_full_n == 1 && mbx2_full_n == 1, "R8 flags kept",
              W'({mbx1_full_n, mbx2_full_n}), 3);

        // R4 / R5
        b_op(0, 1, 0, 1, d2, 0);
        check(mbx2_full_n == 0, "R4 flag2 low", W'(mbx2_full_n), 0);
        b_op(0, 1, 0, 1, d1, 0);
        wait_a(5);
        a_op(0, 1, 0, 1, 0, 0);
        check(a_dout == d2, "R4 R5 mail2 read", a_dout, d2);
        wait_b(5);
        check(mbx2_full_n == 1, "R5 flag2 high", W'(mbx2_full_n), 1);
        a_op(0, 1, 0, 0, 0, 36'h5_5555_0000);
        check(a_dout == 36'h5_5555_0000, "R8 a queue read", a_dout, 36'h5_5555_0000);

        // R7: gated B read keeps output
        held = b_dout;
        b_op(0, 0, 1, 0, 0, 36'h1);
        check(b_dout == held, "R7 b en low read", b_dout, held);

        // R6: partial reset during transfer
        a_op(0, 1, 1, 1, d1, 0);
        b_op(0, 1, 0, 1, d2, 0);
        @(negedge clk_a); part_rst_n = 0;
        wait_a(2);
        check(mbx1_full_n == 1 && mbx2_full_n == 1, "R6 partial reset flags",
              W'({mbx1_full_n, mbx2_full_n}), 3);
        check(b_dout == 0, "R6 partial reset b_dout", b_dout, 0);
        part_rst_n = 1;
        wait_b(3);

        // random round trips
        for (int i = 0; i < 40; i++) begin
            v = {$urandom, $urandom} & {W{1'b1}};
            if ($urandom % 2) begin
                a_op(0, 1, 1, 1, v, 0);
                check(mbx1_full_n == 0, "R1 random", W'(mbx1_full_n), 0);
                if ($urandom % 2) a_op(0, 1, 1, 1, ~v, 0);
                wait_b(5);
                b_op(0, 1, 1, 1, 0, 0);
                check(b_dout == exp_read(1, v, 0), "R3 random", b_dout, v);
                wait_a(5);
                check(mbx1_full_n == 1, "R3 random flag", W'(mbx1_full_n), 1);
            end else begin
                b_op(0, 1, 0, 1, v, 0);
                check(mbx2_full_n == 0, "R4 random", W'(mbx2_full_n), 0);
                if ($urandom % 2) b_op(0, 1, 0, 1, ~v, 0);
                wait_a(5);
                a_op(0, 1, 0, 1, 0, 0);
                check(a_dout == exp_read(1, v, 0), "R5 random", a_dout, v);
                wait_b(5);
                check(mbx2_full_n == 1, "R5 random flag", W'(mbx2_full_n), 1);
            end
            b_op(0, 1, 1, 0, 0, ~v);
            check(b_dout == exp_read(0, 0, ~v), "R8 random", b_dout, ~v);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule